// File: doc/BRIEF.md
# Five-Point Piecewise-Linear ADC Calibrator

The calibrator takes a raw 16-bit straight-binary ADC code and its channel number and returns a corrected code. Each channel keeps five reference codes. They are the raw readings taken at −10 V, −5 V, 0 V, +5 V and +10 V, written here as nFS, nHS, zero, pHS and pFS. The raw value is first compared with nHS, zero and pHS to pick one of four linear segments. The block then scales the raw value's distance from that segment's anchor point by a fixed gain, divides it by the span of the segment, and adds a fixed base code.

Two complete tables are held: one for the ±10 V range and one for the ±5 V range. Each table has one entry per channel. A write port loads single points. A range select and a calibration-type input are sampled together with each conversion. The division runs bit-serially, so only one conversion is in flight at a time. The handshake at the input holds off new work until the result has been delivered.

Top module: `adc_cal_top`

## Requirements
- R1: When raw > pHS, the result is base 0xBFF8 plus trunc((raw − pHS) × 0x3FF8 / (pFS − pHS)). Division truncates toward zero and uses signed 32-bit arithmetic.
- R2: When zero < raw ≤ pHS, the result is 0x8000 plus trunc((raw − zero) × 0x3FF8 / (pHS − zero)). A raw value equal to pHS falls in this segment.
- R3: When nHS ≤ raw ≤ zero, the result is 0x8000 plus trunc((raw − zero) × 0x3FF9 / (zero − nHS)). The numerator is zero or negative here. Raw values equal to zero or to nHS fall in this segment.
- R4: When raw < nHS, the result is 0x4007 plus trunc((raw − nHS) × 0x3FF9 / (nHS − nFS)).
- R5: When cal_type_i is 0 at acceptance, the output equals the raw input. That result is presented in the cycle after acceptance.
- R6: A result that computes below 0 is output as 0x0000, and one that computes above 0xFFFF is output as 0xFFFF.
- R7: When the selected segment's span is zero, no division is made and the output is that segment's base code.
- R8: in_ready_o is high only when idle. It drops in the cycle after an input is accepted and stays low until the result has been presented.
- R9: A table write stores tab_data_i at range tab_range_i, channel tab_ch_i and point tab_pt_i. The point index is 0 = nFS, 1 = nHS, 2 = zero, 3 = pHS, 4 = pFS, and indices 5 to 7 are ignored. A conversion uses the table of the range_i and in_ch_i sampled at acceptance, so writes to other channels or ranges do not change its result.
- R10: Each accepted input produces exactly one out_valid_o pulse, one cycle long. out_data_o is valid during that cycle.
- R11: After reset, in_ready_o is 1, out_valid_o is 0 and every table point is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_type_i | input | 2 | Calibration type; 0 selects pass-through |
| range_i | input | 1 | Table set used by the next conversion |
| tab_we_i | input | 1 | Table point write strobe |
| tab_range_i | input | 1 | Table set of the point written |
| tab_ch_i | input | 4 | Channel of the point written |
| tab_pt_i | input | 3 | Point index 0..4 (nFS..pFS) |
| tab_data_i | input | 16 | Point value |
| in_valid_i | input | 1 | Raw sample offered |
| in_ready_o | output | 1 | Block can accept a sample |
| in_raw_i | input | 16 | Raw straight-binary code |
| in_ch_i | input | 4 | Channel of the raw code |
| out_valid_o | output | 1 | Corrected result strobe |
| out_data_o | output | 16 | Corrected code |

## Verification
Full-scale raw sweeps run against a well-formed table in each range. This shows that the four segments meet at the right breakpoints and that the two range sets stay separate. Directed samples sit at nHS−1, nHS, zero, zero+1, pHS and pHS+1, which separates a wrong comparison from a wrong formula. Tables with one-code spans drive the arithmetic past both ends and catch a missing clamp. Tables with coincident points exercise the zero-span bypass. Pass-through samples and an untouched channel show that cal_type 0 and the reset contents take effect.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int CAL_DW = 16;
  localparam int ACC_W  = 32;
  localparam int NPT    = 5;

  localparam int PT_NFS  = 0;
  localparam int PT_NHS  = 1;
  localparam int PT_ZERO = 2;
  localparam int PT_PHS  = 3;
  localparam int PT_PFS  = 4;

  localparam logic [CAL_DW-1:0] GAIN_POS = 16'h3FF8;
  localparam logic [CAL_DW-1:0] GAIN_NEG = 16'h3FF9;
  localparam logic [CAL_DW-1:0] BASE_S3  = 16'hBFF8;
  localparam logic [CAL_DW-1:0] BASE_MID = 16'h8000;
  localparam logic [CAL_DW-1:0] BASE_S0  = 16'h4007;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_DONE} cal_state_e;

  typedef struct packed {
    logic [ACC_W-1:0]  num_mag;
    logic [ACC_W-1:0]  den_mag;
    logic              neg;
    logic              den_zero;
    logic [CAL_DW-1:0] base;
  } calib_op_t;
endpackage

// File: rtl/cal_table.sv
module cal_table
  import adc_cal_pkg::*;
#(
  parameter int NR  = 2,
  parameter int NCH = 16,
  localparam int RW    = (NR > 1) ? $clog2(NR) : 1,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DEPTH = NR * NCH * NPT,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [RW-1:0]                wr_range_i,
  input  logic [CHW-1:0]               wr_ch_i,
  input  logic [2:0]                   wr_pt_i,
  input  logic [CAL_DW-1:0]            wr_data_i,
  input  logic [RW-1:0]                rd_range_i,
  input  logic [CHW-1:0]               rd_ch_i,
  output logic [NPT-1:0][CAL_DW-1:0]   pts_o
);
  logic [CAL_DW-1:0] mem [DEPTH];
  logic [IW-1:0]     wr_idx;
  logic              wr_ok;
  int                rd_base;

  assign wr_ok   = we_i && (int'(wr_pt_i) < NPT);
  assign wr_idx  = IW'((int'(wr_range_i) * NCH + int'(wr_ch_i)) * NPT + int'(wr_pt_i));
  assign rd_base = (int'(rd_range_i) * NCH + int'(rd_ch_i)) * NPT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_idx] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NPT; p++) begin : g_rd
    assign pts_o[p] = mem[IW'(rd_base + p)];
  end

  p_write_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> mem[$past(wr_idx)] == $past(wr_data_i));
endmodule

// File: rtl/cal_seg_select.sv
module cal_seg_select
  import adc_cal_pkg::*;
(
  input  logic [CAL_DW-1:0]           raw_i,
  input  logic [NPT-1:0][CAL_DW-1:0]  pts_i,
  output calib_op_t                   op_o
);
  logic [CAL_DW-1:0]        anchor, hi, lo, gain;
  logic signed [CAL_DW:0]   diff, span;
  logic signed [ACC_W-1:0]  num, den, gain_s;

  always_comb begin
    // segment by unsigned compare against breakpoints
    if (raw_i > pts_i[PT_PHS]) begin
      anchor = pts_i[PT_PHS];  hi = pts_i[PT_PFS];  lo = pts_i[PT_PHS];
      gain = GAIN_POS;         op_o.base = BASE_S3;
    end else if (raw_i > pts_i[PT_ZERO]) begin
      anchor = pts_i[PT_ZERO]; hi = pts_i[PT_PHS];  lo = pts_i[PT_ZERO];
      gain = GAIN_POS;         op_o.base = BASE_MID;
    end else if (raw_i >= pts_i[PT_NHS]) begin
      anchor = pts_i[PT_ZERO]; hi = pts_i[PT_ZERO]; lo = pts_i[PT_NHS];
      gain = GAIN_NEG;         op_o.base = BASE_MID;
    end else begin
      anchor = pts_i[PT_NHS];  hi = pts_i[PT_NHS];  lo = pts_i[PT_NFS];
      gain = GAIN_NEG;         op_o.base = BASE_S0;
    end
    diff   = $signed({1'b0, raw_i}) - $signed({1'b0, anchor});
    span   = $signed({1'b0, hi}) - $signed({1'b0, lo});
    gain_s = $signed(ACC_W'(gain));
    num    = ACC_W'(diff) * gain_s;
    den    = ACC_W'(span);
    op_o.num_mag  = num[ACC_W-1] ? ACC_W'(-num) : ACC_W'(num);
    op_o.den_mag  = den[ACC_W-1] ? ACC_W'(-den) : ACC_W'(den);
    op_o.neg      = num[ACC_W-1] ^ den[ACC_W-1];
    op_o.den_zero = (span == '0);
  end
endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  logic [W:0]    rem_q, rem_n;
  logic [W-1:0]  dvd_q, dsr_q;
  logic [CW-1:0] cnt_q;

  assign rem_n  = {rem_q[W-1:0], dvd_q[W-1]};
  assign quot_o = dvd_q;
  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvd_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        dvd_q <= dividend_i;
        dsr_q <= divisor_i;
        cnt_q <= CW'(W);
      end else if (busy_o) begin
        if (rem_n >= {1'b0, dsr_q}) begin
          rem_q <= rem_n - {1'b0, dsr_q};
          dvd_q <= {dvd_q[W-2:0], 1'b1};
        end else begin
          rem_q <= rem_n;
          dvd_q <= {dvd_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_o <= 1'b1;
      end
    end
  end

  p_start_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  p_rem_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rem_q < {1'b0, dsr_q});
endmodule

// File: rtl/adc_cal_top.sv
module adc_cal_top
  import adc_cal_pkg::*;
#(
  parameter int NR  = 2,
  parameter int NCH = 16,
  localparam int RW  = (NR > 1) ? $clog2(NR) : 1,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cal_type_i,
  input  logic [RW-1:0]     range_i,
  input  logic              tab_we_i,
  input  logic [RW-1:0]     tab_range_i,
  input  logic [CHW-1:0]    tab_ch_i,
  input  logic [2:0]        tab_pt_i,
  input  logic [CAL_DW-1:0] tab_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CAL_DW-1:0] in_raw_i,
  input  logic [CHW-1:0]    in_ch_i,
  output logic              out_valid_o,
  output logic [CAL_DW-1:0] out_data_o
);
  cal_state_e                  state_q;
  logic [NPT-1:0][CAL_DW-1:0]  pts;
  calib_op_t                   op;
  logic                        acc, bypass, div_start, div_busy, div_done;
  logic [ACC_W-1:0]            quot;
  logic                        neg_q;
  logic [CAL_DW-1:0]           base_q, res_q;
  logic signed [ACC_W+1:0]     sum;

  cal_table #(.NR(NR), .NCH(NCH)) i_table (
    .clk_i, .rst_ni,
    .we_i(tab_we_i), .wr_range_i(tab_range_i), .wr_ch_i(tab_ch_i),
    .wr_pt_i(tab_pt_i), .wr_data_i(tab_data_i),
    .rd_range_i(range_i), .rd_ch_i(in_ch_i), .pts_o(pts)
  );

  cal_seg_select i_seg (.raw_i(in_raw_i), .pts_i(pts), .op_o(op));

  assign in_ready_o = (state_q == ST_IDLE);
  assign acc        = in_valid_i && in_ready_o;
  assign bypass     = (cal_type_i == 2'd0) || op.den_zero;
  assign div_start  = acc && !bypass;

  cal_divider #(.W(ACC_W)) i_div (
    .clk_i, .rst_ni, .start_i(div_start),
    .dividend_i(op.num_mag), .divisor_i(op.den_mag),
    .busy_o(div_busy), .done_o(div_done), .quot_o(quot)
  );

  // base plus signed quotient, then clamp to code range
  always_comb begin
    sum = $signed({2'b00, ACC_W'(base_q)});
    if (neg_q) sum = sum - $signed({2'b00, quot});
    else       sum = sum + $signed({2'b00, quot});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      neg_q   <= 1'b0;
      base_q  <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (acc) begin
          if (cal_type_i == 2'd0) begin
            res_q   <= in_raw_i;
            state_q <= ST_DONE;
          end else if (op.den_zero) begin
            res_q   <= op.base;
            state_q <= ST_DONE;
          end else begin
            neg_q   <= op.neg;
            base_q  <= op.base;
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          if (sum < 0)                           res_q <= '0;
          else if (sum > (2 ** CAL_DW) - 1)      res_q <= '1;
          else                                   res_q <= sum[CAL_DW-1:0];
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o = (state_q == ST_DONE);
  assign out_data_o  = res_q;

  p_one_inflight_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !in_ready_o);
  p_valid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  p_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cal_type_i == 2'd0) |=> (out_valid_o && out_data_o == $past(in_raw_i)));
  p_div_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DIV) |-> !div_busy);
endmodule

// File: tb/test_adc_cal_top.sv
`timescale 1ns/1ps
module test_adc_cal_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cal_type = 2'd1;
  logic        rng = 1'b0;
  logic        we = 1'b0;
  logic        w_rng = 1'b0;
  logic [3:0]  w_ch = '0;
  logic [2:0]  w_pt = '0;
  logic [15:0] w_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_raw = '0;
  logic [3:0]  in_ch = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int total = 0;
  int bad = 0;
  int tab [2][16][5];

  always #4 clk = ~clk;

  adc_cal_top i_adc_cal_top (
    .clk_i(clk), .rst_ni(rst_n), .cal_type_i(cal_type), .range_i(rng),
    .tab_we_i(we), .tab_range_i(w_rng), .tab_ch_i(w_ch), .tab_pt_i(w_pt),
    .tab_data_i(w_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_raw_i(in_raw), .in_ch_i(in_ch), .out_valid_o(out_valid), .out_data_o(out_data)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int model(input int r, input int c, input int raw, input int ctype);
    int nfs, nhs, z, phs, pfs, num, den, base, v;
    if (ctype == 0) return raw;
    nfs = tab[r][c][0]; nhs = tab[r][c][1]; z = tab[r][c][2];
    phs = tab[r][c][3]; pfs = tab[r][c][4];
    if (raw > phs)       begin num = (raw - phs) * 16'h3FF8; den = pfs - phs; base = 16'hBFF8; end
    else if (raw > z)    begin num = (raw - z) * 16'h3FF8;   den = phs - z;   base = 16'h8000; end
    else if (raw >= nhs) begin num = (raw - z) * 16'h3FF9;   den = z - nhs;   base = 16'h8000; end
    else                 begin num = (raw - nhs) * 16'h3FF9; den = nhs - nfs; base = 16'h4007; end
    if (den == 0) return base;
    v = base + num / den;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return v;
  endfunction

  function automatic string seg_tag(input int r, input int c, input int raw, input int ctype);
    int v;
    if (ctype == 0) return "R5";
    if (raw > tab[r][c][3]) return "R1";
    if (raw > tab[r][c][2]) return "R2";
    if (raw >= tab[r][c][1]) return "R3";
    v = 0;
    return (v == 0) ? "R4" : "R4";
  endfunction

  task automatic wr(input int r, input int c, input int p, input int d);
    @(negedge clk);
    we = 1'b1; w_rng = r[0]; w_ch = c[3:0]; w_pt = p[2:0]; w_data = d[15:0];
    @(negedge clk);
    we = 1'b0;
    if (p < 5) tab[r][c][p] = d;
  endtask

  task automatic load(input int r, input int c, input int a, input int b, input int z, input int d, input int e);
    wr(r, c, 0, a); wr(r, c, 1, b); wr(r, c, 2, z); wr(r, c, 3, d); wr(r, c, 4, e);
  endtask

  task automatic conv(input int r, input int c, input int raw, input int ctype, input string tag);
    int n;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; rng = r[0]; in_ch = c[3:0]; in_raw = raw[15:0]; cal_type = ctype[1:0];
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 ready low after accept", int'(in_ready), 0);
    n = 0;
    while (!out_valid && n < 100) begin @(negedge clk); n++; end
    if (!out_valid) check("R10 result timeout", 0, 1);
    else check(tag, int'(out_data), model(r, c, raw, ctype));
    @(negedge clk);
    check("R10 one-cycle pulse", int'(out_valid), 0);
  endtask

  task automatic sweep(input int r, input int c, input int step);
    for (int v = 0; v < 65536; v += step) conv(r, c, v, 1, seg_tag(r, c, v, 1));
    conv(r, c, 65535, 1, seg_tag(r, c, 65535, 1));
  endtask

  task automatic edges(input int r, input int c);
    int pts [6];
    pts[0] = tab[r][c][1] - 1; pts[1] = tab[r][c][1];
    pts[2] = tab[r][c][2];     pts[3] = tab[r][c][2] + 1;
    pts[4] = tab[r][c][3];     pts[5] = tab[r][c][3] + 1;
    for (int i = 0; i < 6; i++)
      if (pts[i] >= 0 && pts[i] < 65536) conv(r, c, pts[i], 1, seg_tag(r, c, pts[i], 1));
  endtask

  initial begin
    for (int a = 0; a < 2; a++) for (int b = 0; b < 16; b++) for (int p = 0; p < 5; p++) tab[a][b][p] = 0;
    repeat (3) @(negedge clk);
    check("R11 ready at reset", int'(in_ready), 1);
    check("R11 valid at reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 ready after reset", int'(in_ready), 1);
    // untouched channel: all-zero points, zero span
    conv(0, 7, 5, 1, "R11 R7 reset table");
    conv(0, 7, 0, 1, "R11 R7 reset table");

    load(0, 3, 16'h0123, 16'h4050, 16'h7FE0, 16'hBF80, 16'hFF00);
    sweep(0, 3, 131);
    edges(0, 3);
    load(1, 3, 16'h2000, 16'h5000, 16'h8000, 16'hB000, 16'hE000);
    sweep(1, 3, 173);
    edges(1, 3);
    // R9: other range must be unaffected
    conv(0, 3, 16'hA000, 1, "R9 range isolation");
    conv(0, 3, 16'h1000, 1, "R9 range isolation");
    // R9: out-of-range point index ignored
    wr(0, 3, 6, 16'h0000);
    wr(0, 3, 7, 16'hFFFF);
    conv(0, 3, 16'h0100, 1, "R9 point index ignored");
    conv(0, 3, 16'hFF80, 1, "R9 point index ignored");

    // R6 saturation via one-code spans
    load(0, 15, 16'h3000, 16'h3010, 16'h8000, 16'hF000, 16'hF001);
    conv(0, 15, 16'h0000, 1, "R6 clamp low");
    check("R6 low value", int'(out_data), 0);
    conv(0, 15, 16'hFFFF, 1, "R6 clamp high");
    check("R6 high value", int'(out_data), 16'hFFFF);
    sweep(0, 15, 1021);

    // R7 zero span
    load(1, 0, 16'h4000, 16'h4000, 16'h8000, 16'hC000, 16'hC000);
    conv(1, 0, 16'hD000, 1, "R7 upper span zero");
    check("R7 upper base", int'(out_data), 16'hBFF8);
    conv(1, 0, 16'h1000, 1, "R7 lower span zero");
    check("R7 lower base", int'(out_data), 16'h4007);
    conv(1, 0, 16'h9000, 1, seg_tag(1, 0, 16'h9000, 1));

    // R5 pass-through
    for (int v = 0; v < 65536; v += 1553) conv(0, 3, v, 0, "R5 pass-through");
    conv(1, 3, 65535, 0, "R5 pass-through");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule